// File: doc/BRIEF.md
# Bus Cycle Timer with Master Control

This block keeps the isochronous cycle time of a serial-bus link node. A 12-bit offset counts ticks of the 24.576 MHz link clock. When it passes 3071, it returns to zero and a 13-bit cycle count advances. The cycle count wraps after 7999 and then advances a 7-bit seconds field. With the internal source, a rollover therefore occurs every 3072 ticks (125 µs). With the external source, a rollover occurs once for each rising edge of an asynchronous cycle input.

When the node is cycle master and the physical layer reports it as root, every rollover also raises a one-clock request to send a cycle-start packet. When the node is not cycle master, cycle-start values received from another node are loaded into the timer, which keeps it in step with the sender. Packet formatting happens elsewhere.

Top module: `busCycleTimer`

## Requirements
- R1: While rstN is 0, offsetOut, cycleCountOut, secondsOut, rollPulse and startReq are all 0.
- R2: With timerEn=1 and extSourceSel=0, offsetOut increases by 1 on each clock. On the clock after it reads 3071, it becomes 0, cycleCountOut increases by 1, and rollPulse is 1 for exactly that one clock.
- R3: When timerEn=0 and no load occurs, the offset, cycle count and seconds hold their values, and rollPulse stays 0.
- R4: A rollover with cycleCountOut=7999 sets it to 0 and increases secondsOut by 1; secondsOut wraps modulo 128.
- R5: With extSourceSel=1, the offset stops at 3071 instead of rolling over. A rollover happens on the third clock edge after extCycleIn rises, and only once per rising edge, however long the input stays high. Edges that arrive while timerEn=0 are lost.
- R6: startReq is 1 only in a clock where rollPulse is 1, masterEn was 1 and isRoot was 1.
- R7: While isRoot=0, startReq stays 0 even when masterEn=1.
- R8: With masterEn=0, a clock with rxStrobe=1 loads rxValue: bits [31:25] go to seconds, [24:12] to the cycle count and [11:0] to the offset. A loaded value above its limit is clamped to the limit minus 1. The loaded value appears after that clock, regardless of timerEn, and rollPulse is 0 in the cycle the load appears.
- R9: With masterEn=1, rxStrobe has no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz link clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerEn | input | 1 | Lets the offset count |
| extSourceSel | input | 1 | 1: rollover on external input; 0: internal count |
| masterEn | input | 1 | Node acts as cycle master |
| isRoot | input | 1 | Physical layer reports the node as root |
| extCycleIn | input | 1 | Asynchronous external cycle event |
| rxStrobe | input | 1 | A received cycle-start value is valid |
| rxValue | input | 32 | Received seconds / cycle / offset |
| offsetOut | output | 12 | Current offset (0..3071) |
| cycleCountOut | output | 13 | Current cycle count (0..7999) |
| secondsOut | output | 7 | Current seconds |
| rollPulse | output | 1 | One-clock rollover indication |
| startReq | output | 1 | One-clock request to send a cycle start |

## Verification
A wrong offset state shows at offsetOut on the next clock. A wrong limit compare shows at the latest within 3072 clocks, as a missing or misplaced rollPulse and a wrong cycle count. A faulty cycle-count wrap is reached at once by loading 7999 and offset 3070, so it shows at secondsOut within two clocks. Errors in the synchroniser and the edge detector show as rollPulse arriving on the wrong edge or repeating while extCycleIn stays high. Errors in master and root gating show on startReq in the very clock of the rollover.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  typedef struct packed {
    logic tick;
    logic roll;
    logic load;
  } timerStrobes_t;
endpackage

// File: rtl/cycTimerCtrl.sv
module cycTimerCtrl
  import cyc_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          timerEn,
  input  logic          extSourceSel,
  input  logic          masterEn,
  input  logic          isRoot,
  input  logic          extCycleIn,
  input  logic          rxStrobe,
  input  logic          atLimit,
  output timerStrobes_t strobes,
  output logic          rollPulse,
  output logic          startReq
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncPrev;
  logic extEdge;
  logic loadNow;
  logic rollNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      syncPrev  <= 1'b0;
      rollPulse <= 1'b0;
      startReq  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], extCycleIn};
      syncPrev  <= syncChain[SYNC_STAGES-1];
      rollPulse <= rollNow;
      startReq  <= rollNow && masterEn && isRoot;
    end
  end

  always_comb begin
    extEdge = syncChain[SYNC_STAGES-1] && !syncPrev;
    loadNow = rxStrobe && !masterEn;
    rollNow = !loadNow && timerEn && (extSourceSel ? extEdge : atLimit);
    strobes.load = loadNow;
    strobes.roll = rollNow;
    strobes.tick = !loadNow && timerEn && !atLimit;
  end

  // R6: a start request only ever accompanies a rollover
  assert_start_with_roll_R6: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> rollPulse);
  // R7: no request when not root
  assert_no_start_not_root_R7: assert property (@(posedge clk) disable iff (!rstN)
    !isRoot |=> !startReq);
  // R8: a load never shows a rollover in the cycle it lands
  assert_load_no_roll_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && !masterEn) |=> !rollPulse);
endmodule

// File: rtl/cycTimerDatapath.sv
module cycTimerDatapath
  import cyc_timer_pkg::*;
#(
  parameter int OFFSET_LIMIT = 3072,
  parameter int CYCLE_LIMIT  = 8000,
  parameter int SEC_W        = 7,
  localparam int OFFSET_W = $clog2(OFFSET_LIMIT),
  localparam int CYCLE_W  = $clog2(CYCLE_LIMIT),
  localparam int RX_W     = SEC_W + CYCLE_W + OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  timerStrobes_t       strobes,
  input  logic [RX_W-1:0]     rxValue,
  output logic [OFFSET_W-1:0] offset,
  output logic [CYCLE_W-1:0]  cycleCount,
  output logic [SEC_W-1:0]    seconds,
  output logic                atLimit
);
  localparam logic [OFFSET_W-1:0] OFFSET_MAX = OFFSET_W'(OFFSET_LIMIT - 1);
  localparam logic [CYCLE_W-1:0]  CYCLE_MAX  = CYCLE_W'(CYCLE_LIMIT - 1);

  logic [OFFSET_W-1:0] rxOffset;
  logic [CYCLE_W-1:0]  rxCycle;
  logic [SEC_W-1:0]    rxSeconds;

  always_comb begin
    rxOffset  = rxValue[OFFSET_W-1:0];
    rxCycle   = rxValue[OFFSET_W +: CYCLE_W];
    rxSeconds = rxValue[RX_W-1 -: SEC_W];
    if (rxOffset > OFFSET_MAX) rxOffset = OFFSET_MAX;
    if (rxCycle > CYCLE_MAX) rxCycle = CYCLE_MAX;
    atLimit = (offset == OFFSET_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset     <= '0;
      cycleCount <= '0;
      seconds    <= '0;
    end else if (strobes.load) begin
      offset     <= rxOffset;
      cycleCount <= rxCycle;
      seconds    <= rxSeconds;
    end else if (strobes.roll) begin
      offset <= '0;
      if (cycleCount == CYCLE_MAX) begin
        cycleCount <= '0;
        seconds    <= seconds + 1'b1;
      end else begin
        cycleCount <= cycleCount + 1'b1;
      end
    end else if (strobes.tick) begin
      offset <= offset + 1'b1;
    end
  end

  // R2: offset stays inside its range
  assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    offset <= OFFSET_MAX);
  // R4: cycle count stays inside its range
  assert_cycle_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cycleCount <= CYCLE_MAX);
endmodule

// File: rtl/busCycleTimer.sv
module busCycleTimer
  import cyc_timer_pkg::*;
#(
  parameter int OFFSET_LIMIT = 3072,
  parameter int CYCLE_LIMIT  = 8000,
  parameter int SEC_W        = 7,
  parameter int SYNC_STAGES  = 2,
  localparam int OFFSET_W = $clog2(OFFSET_LIMIT),
  localparam int CYCLE_W  = $clog2(CYCLE_LIMIT),
  localparam int RX_W     = SEC_W + CYCLE_W + OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                timerEn,
  input  logic                extSourceSel,
  input  logic                masterEn,
  input  logic                isRoot,
  input  logic                extCycleIn,
  input  logic                rxStrobe,
  input  logic [RX_W-1:0]     rxValue,
  output logic [OFFSET_W-1:0] offsetOut,
  output logic [CYCLE_W-1:0]  cycleCountOut,
  output logic [SEC_W-1:0]    secondsOut,
  output logic                rollPulse,
  output logic                startReq
);
  timerStrobes_t strobes;
  logic atLimit;

  cycTimerCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .extSourceSel(extSourceSel),
    .masterEn(masterEn), .isRoot(isRoot), .extCycleIn(extCycleIn),
    .rxStrobe(rxStrobe), .atLimit(atLimit), .strobes(strobes),
    .rollPulse(rollPulse), .startReq(startReq)
  );

  cycTimerDatapath #(
    .OFFSET_LIMIT(OFFSET_LIMIT), .CYCLE_LIMIT(CYCLE_LIMIT), .SEC_W(SEC_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxValue(rxValue),
    .offset(offsetOut), .cycleCount(cycleCountOut), .seconds(secondsOut),
    .atLimit(atLimit)
  );

  // R2: a rollover always lands on offset zero
  assert_roll_at_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rollPulse |-> offsetOut == '0);
  // R3: disabled and not loading means the time holds
  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !rxStrobe) |=> ($stable(offsetOut) && $stable(cycleCountOut)
                                 && $stable(secondsOut) && !rollPulse));
  // R9: strobe while master changes nothing when disabled
  assert_master_ignores_rx_R9: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn && !timerEn) |=> $stable(offsetOut));
endmodule

// File: tb/test_busCycleTimer.sv
module test_busCycleTimer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timerEn = 1'b0, extSourceSel = 1'b0, masterEn = 1'b0, isRoot = 1'b0;
  logic extCycleIn = 1'b0, rxStrobe = 1'b0;
  logic [31:0] rxValue = '0;
  logic [11:0] offsetOut;
  logic [12:0] cycleCountOut;
  logic [6:0]  secondsOut;
  logic rollPulse, startReq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  busCycleTimer i_busCycleTimer (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .extSourceSel(extSourceSel),
    .masterEn(masterEn), .isRoot(isRoot), .extCycleIn(extCycleIn),
    .rxStrobe(rxStrobe), .rxValue(rxValue), .offsetOut(offsetOut),
    .cycleCountOut(cycleCountOut), .secondsOut(secondsOut),
    .rollPulse(rollPulse), .startReq(startReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] packRx(int s, int c, int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  task automatic loadValue(input int s, input int c, input int o);
    masterEn = 1'b0; rxValue = packRx(s, c, o); rxStrobe = 1'b1;
    step(1);
    rxStrobe = 1'b0;
  endtask

  task automatic testReset();
    step(3);
    check("R1 offset", offsetOut, 0);
    check("R1 cycle", cycleCountOut, 0);
    check("R1 seconds", secondsOut, 0);
    check("R1 roll", rollPulse, 0);
    check("R1 start", startReq, 0);
    rstN = 1'b1; timerEn = 1'b1; masterEn = 1'b1; isRoot = 1'b1;
  endtask

  task automatic testInternal();
    step(5);
    check("R2 offset after 5", offsetOut, 5);
    step(3066);
    check("R2 offset at max", offsetOut, 3071);
    check("R2 no early roll", rollPulse, 0);
    step(1);
    check("R2 wrap offset", offsetOut, 0);
    check("R2 cycle inc", cycleCountOut, 1);
    check("R2 roll pulse", rollPulse, 1);
    check("R6 start req", startReq, 1);
    step(1);
    check("R2 roll one clock", rollPulse, 0);
    check("R6 start one clock", startReq, 0);
    check("R2 offset 1", offsetOut, 1);
  endtask

  task automatic testNotRoot();
    isRoot = 1'b0;
    step(3071);
    check("R7 roll happens", rollPulse, 1);
    check("R7 cycle", cycleCountOut, 2);
    check("R7 start suppressed", startReq, 0);
    isRoot = 1'b1;
  endtask

  task automatic testHold();
    int o, c;
    step(7);
    timerEn = 1'b0;
    step(1);
    o = offsetOut; c = cycleCountOut;
    step(10);
    check("R3 offset held", offsetOut, o);
    check("R3 cycle held", cycleCountOut, c);
    check("R3 no roll", rollPulse, 0);
    masterEn = 1'b1; rxValue = packRx(9, 99, 999); rxStrobe = 1'b1;
    step(1);
    rxStrobe = 1'b0;
    check("R9 ignored offset", offsetOut, o);
    check("R9 ignored cycle", cycleCountOut, c);
  endtask

  task automatic testLoadWrap();
    timerEn = 1'b0;
    loadValue(5, 7999, 3070);
    check("R8 loaded offset", offsetOut, 3070);
    check("R8 loaded cycle", cycleCountOut, 7999);
    check("R8 loaded seconds", secondsOut, 5);
    timerEn = 1'b1;
    step(1);
    check("R8 counts on", offsetOut, 3071);
    step(1);
    check("R4 cycle wrap", cycleCountOut, 0);
    check("R4 seconds inc", secondsOut, 6);
    check("R4 roll", rollPulse, 1);
    check("R6 not master no start", startReq, 0);
    loadValue(127, 7999, 3071);
    check("R8 no roll on load", rollPulse, 0);
    check("R8 load at max", offsetOut, 3071);
    step(1);
    check("R4 seconds wrap", secondsOut, 0);
    loadValue(1, 8191, 4095);
    check("R8 clamp offset", offsetOut, 3071);
    check("R8 clamp cycle", cycleCountOut, 7999);
  endtask

  task automatic testExternal();
    extSourceSel = 1'b1;
    loadValue(0, 10, 3000);
    masterEn = 1'b1; isRoot = 1'b1;
    step(100);
    check("R5 offset stops", offsetOut, 3071);
    check("R5 no internal roll", cycleCountOut, 10);
    extCycleIn = 1'b1;
    step(2);
    check("R5 not yet", rollPulse, 0);
    step(1);
    check("R5 roll", rollPulse, 1);
    check("R5 offset zero", offsetOut, 0);
    check("R5 cycle", cycleCountOut, 11);
    check("R6 ext start", startReq, 1);
    step(20);
    check("R5 single roll", cycleCountOut, 11);
    check("R5 offset runs", offsetOut, 20);
    extCycleIn = 1'b0;
    step(5);
    extCycleIn = 1'b1;
    step(3);
    check("R5 second edge", cycleCountOut, 12);
    extCycleIn = 1'b0;
    step(5);
    timerEn = 1'b0;
    extCycleIn = 1'b1;
    step(6);
    timerEn = 1'b1;
    step(3);
    check("R5 edge lost when off", cycleCountOut, 12);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testInternal();
    testNotRoot();
    testHold();
    testLoadWrap();
    testExternal();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule